// File: doc/BRIEF.md
# Two-Wire Bus Read Master

This block is the receive side of a two-wire serial bus master. It runs read transfers from one slave device. A start pulse launches a transfer to a 7-bit slave address. The block then generates the bus start condition and sends the address byte. It checks the slave's acknowledge and clocks in data bytes, which it places in a receive holding register. Software, or a DMA channel that watches the ready level, takes each byte out of that register.

The length of a transfer is not programmed as a count. A stop pulse decides where it ends. If the stop pulse comes together with the start pulse, the read is one byte long. If it comes after a byte has arrived, the byte that follows is the final one. The master refuses that final byte by leaving the acknowledge bit released, and then ends the transfer with a stop condition. An optional internal-address phase first writes one byte to the slave and then turns the bus around with a repeated start before the read. Both bus lines are open-drain: each has an output enable that pulls the line low, and the data line also has an input. The bit rate comes from a run-time divider.

Top module: `twi_rd_master`

## Requirements
- R1: After reset, txComp is 1, rxRdy, dmaReq, nackFlag and ovrFlag are 0, and both bus enables (sclOe, sdaOe; 1 = pull the line low) are 0.
- R2: A startReq pulse while idle drops txComp on the next clock edge and produces a start condition: the data line falls while the clock line is high.
- R3: The first byte on the bus is the 7-bit slave address, most significant bit first. The eighth bit is the direction: 1 for a read when no internal address is used.
- R4: If the address byte is not acknowledged (data line high during the ninth clock pulse), nackFlag is set, no data is read, a stop condition ends the transfer, and txComp returns to 1. nackFlag stays set until a statusRead pulse.
- R5: A stopReq given in the same cycle as startReq yields a one-byte read, and that byte is not acknowledged.
- R6: A stopReq given after byte n-1 has arrived makes byte n the last. Bytes 1 to n-1 are acknowledged (data line low on the ninth pulse), byte n is not, and a stop condition follows.
- R7: When a byte completes, it is loaded into rxData and rxRdy rises. An rhrRead pulse clears rxRdy. dmaReq always equals rxRdy.
- R8: If a byte completes while rxRdy is still 1, rxData takes the new byte and ovrFlag is set. statusRead clears ovrFlag and leaves rxRdy unchanged.
- R9: With useIadr = 1, the block sends the address with direction 0, then the intAddr byte, then a repeated start, then the address with direction 1, and then reads.
- R10: Outside start and stop conditions, the data line changes only while the clock line is low. A transfer shows exactly one start (two with an internal address) and one stop.
- R11: Each high phase of the clock line lasts 2*(divCfg+1) clock cycles; divCfg must be at least 2.
- R12: txComp stays 0 from the accepted start until the stop condition has completed, including after the last byte has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| divCfg | input | DIV_W | Quarter-bit period minus one, in clock cycles |
| startReq | input | 1 | One-cycle pulse that launches a read |
| stopReq | input | 1 | One-cycle pulse that makes the next byte the last |
| useIadr | input | 1 | Send an internal-address byte before reading |
| slvAddr | input | DATA_W-1 | Slave address, sampled at start |
| intAddr | input | DATA_W | Internal address byte, sampled at start |
| rhrRead | input | 1 | Pulse: holding register has been read |
| statusRead | input | 1 | Pulse: status has been read (clears nackFlag and ovrFlag) |
| rxData | output | DATA_W | Receive holding register |
| rxRdy | output | 1 | Holding register has an unread byte |
| dmaReq | output | 1 | Level receive request for a DMA channel |
| nackFlag | output | 1 | Address was not acknowledged |
| ovrFlag | output | 1 | A byte was overwritten before it was read |
| txComp | output | 1 | No transfer in progress |
| sclOe | output | 1 | Pull clock line low |
| sdaOe | output | 1 | Pull data line low |
| sdaIn | input | 1 | Data line level |

## Verification
The hardest case to reach is the end of a transfer set by a stop request that arrives while bytes are already moving. The request has to land after byte n-1 is in the holding register and before byte n starts. The bench gets there by polling rxRdy and pulsing stopReq in the same cycle that it reads the byte. A bus-level slave model then counts acknowledges against refusals, so an off-by-one in the last-byte decision shows up as a wrong count. The overrun path uses the same timing but never reads the register, so the second byte lands on an unread first byte.

// File: rtl/twi_rd_pkg.sv
`timescale 1ns/1ps
package twi_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_IADR,
    ST_RSTART,
    ST_DATA,
    ST_STOP
  } busState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic run;        // divider may count
    logic capture;    // latch address inputs
    logic loadAddrW;  // shift register <- {addr, 0}
    logic loadAddrR;  // shift register <- {addr, 1}
    logic loadIadr;   // shift register <- internal address
    logic sample;     // capture data line level
    logic shiftIn;    // shift sampled bit in
    logic loadRhr;    // holding register <- completed byte
    logic setNack;    // raise address-refused flag
  } dpStrobe_t;

endpackage

// File: rtl/twi_rd_dp.sv
`timescale 1ns/1ps
module twi_rd_dp
  import twi_rd_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DIV_W-1:0]  divCfg,
  input  logic [DATA_W-2:0] slvAddr,
  input  logic [DATA_W-1:0] intAddr,
  input  logic              sdaIn,
  input  logic              rhrRead,
  input  logic              statusRead,
  output logic              tick,
  output logic              txBit,
  output logic              smpBit,
  output logic [DATA_W-1:0] rxData,
  output logic              rxRdy,
  output logic              nackFlag,
  output logic              ovrFlag
);

  localparam int ADDR_W = DATA_W - 1;

  logic              sdaS;
  logic [DIV_W-1:0]  divCnt;
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] addrSel;
  logic [DATA_W-1:0] iadrQ;
  logic [DATA_W-1:0] shReg;

  // Input synchronizer, depth chosen by parameter
  generate
    if (SYNC_STAGES > 0) begin : g_sync
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncQ <= '1;
        end else begin
          syncQ[0] <= sdaIn;
          for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
        end
      end
      assign sdaS = syncQ[SYNC_STAGES-1];
    end else begin : g_nosync
      assign sdaS = sdaIn;
    end
  endgenerate

  // Quarter-bit divider
  assign tick = strb.run && (divCnt == divCfg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (!strb.run || tick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  // Address capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      iadrQ <= '0;
    end else if (strb.capture) begin
      addrQ <= slvAddr;
      iadrQ <= intAddr;
    end
  end

  assign addrSel = strb.capture ? slvAddr : addrQ;

  // Shared transmit/receive shift register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else if (strb.loadAddrW) shReg <= {addrSel, 1'b0};
    else if (strb.loadAddrR) shReg <= {addrSel, 1'b1};
    else if (strb.loadIadr) shReg <= iadrQ;
    else if (strb.shiftIn) shReg <= {shReg[DATA_W-2:0], smpBit};
  end

  assign txBit = shReg[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) smpBit <= 1'b1;
    else if (strb.sample) smpBit <= sdaS;
  end

  // Holding register and status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
      rxRdy  <= 1'b0;
    end else if (strb.loadRhr) begin
      rxData <= {shReg[DATA_W-2:0], smpBit};
      rxRdy  <= 1'b1;
    end else if (rhrRead) begin
      rxRdy  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovrFlag <= 1'b0;
    else if (strb.loadRhr && rxRdy && !rhrRead) ovrFlag <= 1'b1;
    else if (statusRead) ovrFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nackFlag <= 1'b0;
    else if (strb.setNack) nackFlag <= 1'b1;
    else if (statusRead) nackFlag <= 1'b0;
  end

  AST_RXRDY_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadRhr |=> rxRdy); // R7

  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadRhr && rxRdy && !rhrRead) |=> (ovrFlag && rxRdy)); // R8

  AST_NACK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (nackFlag && !statusRead) |=> nackFlag); // R4

endmodule

// File: rtl/twi_rd_ctrl.sv
`timescale 1ns/1ps
module twi_rd_ctrl
  import twi_rd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      stopReq,
  input  logic      useIadr,
  input  logic      tick,
  input  logic      txBit,
  input  logic      smpBit,
  output dpStrobe_t strb,
  output logic      sclOe,
  output logic      sdaOe,
  output logic      txComp
);

  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [BIT_W-1:0] ACK_IDX  = BIT_W'(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  busState_t        state;
  logic [1:0]       q;
  logic [BIT_W-1:0] bitCnt;
  logic             addrRead;
  logic             lastByte;
  logic             stopPend;

  logic smpSlot, endSlot, isBitState, dataBit, ackSlot, capture;
  logic sclLowC, sdaLowC, sdaHold;

  assign smpSlot    = tick && (q == 2'd2);
  assign endSlot    = tick && (q == 2'd3);
  assign isBitState = (state == ST_ADDR) || (state == ST_IADR) || (state == ST_DATA);
  assign dataBit    = bitCnt < ACK_IDX;
  assign ackSlot    = endSlot && (bitCnt == ACK_IDX);
  assign capture    = (state == ST_IDLE) && startReq;

  // Strobes to the datapath
  always_comb begin
    strb           = '0;
    strb.run       = (state != ST_IDLE);
    strb.capture   = capture;
    strb.loadAddrW = capture && useIadr;
    strb.loadAddrR = (capture && !useIadr) ||
                     (ackSlot && (state == ST_IADR) && !smpBit);
    strb.loadIadr  = ackSlot && (state == ST_ADDR) && !smpBit && !addrRead;
    strb.sample    = smpSlot && isBitState;
    strb.shiftIn   = endSlot && isBitState && dataBit;
    strb.loadRhr   = endSlot && (state == ST_DATA) && (bitCnt == LAST_BIT);
    strb.setNack   = ackSlot && ((state == ST_ADDR) || (state == ST_IADR)) && smpBit;
  end

  // Sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      q        <= 2'd0;
      bitCnt   <= '0;
      addrRead <= 1'b0;
      lastByte <= 1'b0;
      stopPend <= 1'b0;
      txComp   <= 1'b1;
    end else if (capture) begin
      state    <= ST_START;
      q        <= 2'd0;
      bitCnt   <= '0;
      addrRead <= !useIadr;
      lastByte <= 1'b0;
      stopPend <= stopReq;
      txComp   <= 1'b0;
    end else begin
      if (stopReq && (state != ST_IDLE)) stopPend <= 1'b1;
      if (tick) q <= q + 2'd1;
      if (endSlot) begin
        case (state)
          ST_START, ST_RSTART: begin
            state  <= ST_ADDR;
            bitCnt <= '0;
          end
          ST_ADDR: begin
            if (dataBit) begin
              bitCnt <= bitCnt + 1'b1;
            end else if (smpBit) begin
              state <= ST_STOP;
            end else if (addrRead) begin
              state    <= ST_DATA;
              bitCnt   <= '0;
              lastByte <= stopPend || stopReq;
            end else begin
              state  <= ST_IADR;
              bitCnt <= '0;
            end
          end
          ST_IADR: begin
            if (dataBit) begin
              bitCnt <= bitCnt + 1'b1;
            end else if (smpBit) begin
              state <= ST_STOP;
            end else begin
              state    <= ST_RSTART;
              addrRead <= 1'b1;
            end
          end
          ST_DATA: begin
            if (dataBit) begin
              bitCnt <= bitCnt + 1'b1;
            end else if (lastByte) begin
              state <= ST_STOP;
            end else begin
              bitCnt   <= '0;
              lastByte <= stopPend || stopReq;
            end
          end
          ST_STOP: begin
            state  <= ST_IDLE;
            txComp <= 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // Line levels per quarter of a bit slot
  always_comb begin
    sclLowC = 1'b0;
    sdaLowC = 1'b0;
    case (state)
      ST_START, ST_RSTART: begin
        sclLowC = (q < 2'd2);
        sdaLowC = (q == 2'd3);
      end
      ST_ADDR, ST_IADR: begin
        sclLowC = (q < 2'd2);
        sdaLowC = dataBit ? !txBit : 1'b0;
      end
      ST_DATA: begin
        sclLowC = (q < 2'd2);
        sdaLowC = dataBit ? 1'b0 : !lastByte;
      end
      ST_STOP: begin
        sclLowC = (q < 2'd2);
        sdaLowC = (q != 2'd3);
      end
      default: begin
        sclLowC = 1'b0;
        sdaLowC = 1'b0;
      end
    endcase
  end

  assign sdaHold = (state != ST_IDLE) && (q == 2'd0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclOe <= 1'b0;
      sdaOe <= 1'b0;
    end else begin
      sclOe <= sclLowC;
      if (!sdaHold) sdaOe <= sdaLowC;
    end
  end

  AST_START_DROPS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) && startReq) |=> (!txComp && (state == ST_START))); // R2

  AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txComp) |-> ($past(state) == ST_STOP)); // R12

  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (isBitState && $past(isBitState) && !sclOe && !$past(sclOe)) |-> $stable(sdaOe)); // R10

endmodule

// File: rtl/twi_rd_master.sv
`timescale 1ns/1ps
module twi_rd_master
  import twi_rd_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divCfg,
  input  logic              startReq,
  input  logic              stopReq,
  input  logic              useIadr,
  input  logic [DATA_W-2:0] slvAddr,
  input  logic [DATA_W-1:0] intAddr,
  input  logic              rhrRead,
  input  logic              statusRead,
  output logic [DATA_W-1:0] rxData,
  output logic              rxRdy,
  output logic              dmaReq,
  output logic              nackFlag,
  output logic              ovrFlag,
  output logic              txComp,
  output logic              sclOe,
  output logic              sdaOe,
  input  logic              sdaIn
);

  dpStrobe_t strb;
  logic      tick;
  logic      txBit;
  logic      smpBit;

  twi_rd_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .stopReq  (stopReq),
    .useIadr  (useIadr),
    .tick     (tick),
    .txBit    (txBit),
    .smpBit   (smpBit),
    .strb     (strb),
    .sclOe    (sclOe),
    .sdaOe    (sdaOe),
    .txComp   (txComp)
  );

  twi_rd_dp #(
    .DIV_W       (DIV_W),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .divCfg     (divCfg),
    .slvAddr    (slvAddr),
    .intAddr    (intAddr),
    .sdaIn      (sdaIn),
    .rhrRead    (rhrRead),
    .statusRead (statusRead),
    .tick       (tick),
    .txBit      (txBit),
    .smpBit     (smpBit),
    .rxData     (rxData),
    .rxRdy      (rxRdy),
    .nackFlag   (nackFlag),
    .ovrFlag    (ovrFlag)
  );

  assign dmaReq = rxRdy;

endmodule

// File: tb/twi_rd_master_tb.sv
`timescale 1ns/1ps
module twi_rd_master_tb;

  localparam logic [6:0] SLV_ADDR = 7'h2C;
  localparam int P_IDLE = 0, P_ADR = 1, P_IADR = 2, P_WAIT = 3, P_RD = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] divCfg = 8'd3;
  logic       startReq = 1'b0, stopReq = 1'b0, useIadr = 1'b0;
  logic [6:0] slvAddr = 7'h0;
  logic [7:0] intAddr = 8'h0;
  logic       rhrRead = 1'b0, statusRead = 1'b0;
  logic [7:0] rxData;
  logic       rxRdy, dmaReq, nackFlag, ovrFlag, txComp, sclOe, sdaOe;

  logic slvLow = 1'b0;
  wire  sclBus = !sclOe;
  wire  sdaBus = !(sdaOe || slvLow);

  int nChecks = 0, nFail = 0;

  always #2.5 clk = !clk;

  twi_rd_master u_dut (
    .clk(clk), .rstN(rstN), .divCfg(divCfg), .startReq(startReq), .stopReq(stopReq),
    .useIadr(useIadr), .slvAddr(slvAddr), .intAddr(intAddr), .rhrRead(rhrRead),
    .statusRead(statusRead), .rxData(rxData), .rxRdy(rxRdy), .dmaReq(dmaReq),
    .nackFlag(nackFlag), .ovrFlag(ovrFlag), .txComp(txComp), .sclOe(sclOe),
    .sdaOe(sdaOe), .sdaIn(sdaBus)
  );

  // ---------------- slave model ----------------
  logic busReady = 1'b0;
  int   ph = P_IDLE, bitIdx = 0, byteNo = 0;
  int   startCnt = 0, stopCnt = 0, ackCnt = 0, nackCnt = 0;
  logic [7:0] sh = 8'h0, base = 8'h40, lastW = 8'h0, lastR = 8'h0, lastIa = 8'h0;
  logic addrOk = 1'b0, rw = 1'b0, mNack = 1'b0;
  real  tRise = 0.0, hiW = 0.0;

  function automatic logic [7:0] expByte(input logic [7:0] b, input int k);
    return b + 8'(3 * k + 1);
  endfunction

  always @(negedge sdaBus) if (busReady && sclBus === 1'b1) begin
    if (ph == P_IDLE) base = 8'h40;
    ph = P_ADR; bitIdx = 0; slvLow = 1'b0; startCnt++;
  end

  always @(posedge sdaBus) if (busReady && sclBus === 1'b1) begin
    ph = P_IDLE; slvLow = 1'b0; stopCnt++;
  end

  always @(posedge sclBus) begin
    tRise = $realtime;
    if (busReady && ph != P_IDLE && ph != P_WAIT) begin
      if (bitIdx < 8) sh = {sh[6:0], sdaBus};
      else if (ph == P_RD) mNack = sdaBus;
      bitIdx++;
    end
  end

  always @(negedge sclBus) begin
    logic [7:0] cur;
    if (busReady) hiW = $realtime - tRise;
    case (ph)
      P_ADR: begin
        if (bitIdx == 8) begin
          if (sh[0]) lastR = sh; else lastW = sh;
          addrOk = (sh[7:1] == SLV_ADDR); rw = sh[0]; slvLow = addrOk;
        end else if (bitIdx == 9) begin
          slvLow = 1'b0; bitIdx = 0;
          if (!addrOk) ph = P_IDLE;
          else if (rw) begin
            ph = P_RD; byteNo = 0; cur = expByte(base, 0); slvLow = !cur[7];
          end else ph = P_IADR;
        end
      end
      P_IADR: begin
        if (bitIdx == 8) begin lastIa = sh; base = sh; slvLow = 1'b1; end
        else if (bitIdx == 9) begin slvLow = 1'b0; ph = P_WAIT; end
      end
      P_RD: begin
        cur = expByte(base, byteNo);
        if (bitIdx >= 1 && bitIdx <= 7) slvLow = !cur[7 - bitIdx];
        else if (bitIdx == 8) slvLow = 1'b0;
        else if (bitIdx == 9) begin
          if (mNack) begin nackCnt++; ph = P_IDLE; end
          else begin
            ackCnt++; byteNo++; bitIdx = 0;
            cur = expByte(base, byteNo); slvLow = !cur[7];
          end
        end
      end
      default: ;
    endcase
  end

  // ---------------- check helpers ----------------
  task automatic chkEq(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic waitRx();
    while (!rxRdy) @(negedge clk);
  endtask

  task automatic waitDone();
    while (!txComp) @(negedge clk);
  endtask

  task automatic doRead(input logic [6:0] a, input logic iaEn, input logic [7:0] ia,
                        input int n, input string req);
    int s0, p0, a0, k0;
    logic [7:0] b0;
    s0 = startCnt; p0 = stopCnt; a0 = ackCnt; k0 = nackCnt;
    b0 = iaEn ? ia : 8'h40;
    @(negedge clk);
    slvAddr = a; useIadr = iaEn; intAddr = ia; startReq = 1'b1; stopReq = (n == 1);
    @(negedge clk);
    startReq = 1'b0; stopReq = 1'b0;
    chkEq("R2", "txComp after start", int'(txComp), 0);
    for (int k = 0; k < n; k++) begin
      waitRx();
      chkEq("R7", $sformatf("byte %0d", k), int'(rxData), int'(expByte(b0, k)));
      chkEq("R7", "dmaReq with rxRdy", int'(dmaReq), 1);
      if (k == n - 2) stopReq = 1'b1;
      rhrRead = 1'b1;
      @(negedge clk);
      rhrRead = 1'b0; stopReq = 1'b0;
      chkEq("R7", "rxRdy after read", int'(rxRdy), 0);
      if (k == n - 1) chkEq("R12", "txComp after last byte", int'(txComp), 0);
    end
    waitDone();
    chkEq(req, "acked bytes", ackCnt - a0, n - 1);
    chkEq(req, "refused bytes", nackCnt - k0, 1);
    chkEq("R10", "stop count", stopCnt - p0, 1);
    chkEq("R10", "start count", startCnt - s0, iaEn ? 2 : 1);
    chkEq("R3", "read address byte", int'(lastR), int'({a, 1'b1}));
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    chkEq("R1", "txComp", int'(txComp), 1);
    chkEq("R1", "rxRdy/dmaReq", int'({rxRdy, dmaReq}), 0);
    chkEq("R1", "nack/ovr", int'({nackFlag, ovrFlag}), 0);
    chkEq("R1", "bus enables", int'({sclOe, sdaOe}), 0);
  endtask

  task automatic testSingle();
    doRead(SLV_ADDR, 1'b0, 8'h00, 1, "R5");
    chkEq("R11", "scl high ns div3", int'(hiW), 40);
  endtask

  task automatic testMulti();
    doRead(SLV_ADDR, 1'b0, 8'h00, 4, "R6");
  endtask

  task automatic testIadr();
    doRead(SLV_ADDR, 1'b1, 8'h90, 3, "R9");
    chkEq("R9", "write address byte", int'(lastW), int'({SLV_ADDR, 1'b0}));
    chkEq("R9", "internal address byte", int'(lastIa), 'h90);
  endtask

  task automatic testAddrNack();
    int p0, a0;
    p0 = stopCnt; a0 = ackCnt;
    @(negedge clk);
    slvAddr = 7'h11; useIadr = 1'b0; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitDone();
    chkEq("R4", "nackFlag", int'(nackFlag), 1);
    chkEq("R4", "rxRdy", int'(rxRdy), 0);
    chkEq("R4", "stop issued", stopCnt - p0, 1);
    chkEq("R4", "no data acks", ackCnt - a0, 0);
    repeat (40) @(negedge clk);
    chkEq("R4", "nackFlag held", int'(nackFlag), 1);
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
    chkEq("R4", "nackFlag cleared", int'(nackFlag), 0);
  endtask

  task automatic testOverrun();
    @(negedge clk);
    slvAddr = SLV_ADDR; useIadr = 1'b0; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitRx();
    chkEq("R8", "ovr before overwrite", int'(ovrFlag), 0);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    waitDone();
    chkEq("R8", "overwritten data", int'(rxData), int'(expByte(8'h40, 1)));
    chkEq("R8", "ovrFlag", int'(ovrFlag), 1);
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
    chkEq("R8", "ovr cleared", int'(ovrFlag), 0);
    chkEq("R8", "rxRdy kept", int'(rxRdy), 1);
    rhrRead = 1'b1;
    @(negedge clk);
    rhrRead = 1'b0;
    chkEq("R7", "dmaReq cleared", int'(dmaReq), 0);
  endtask

  task automatic testDivider();
    @(negedge clk);
    divCfg = 8'd5;
    doRead(SLV_ADDR, 1'b0, 8'h00, 2, "R6");
    chkEq("R11", "scl high ns div5", int'(hiW), 60);
    divCfg = 8'd3;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    busReady = 1'b1;
    testReset();
    testSingle();
    testMulti();
    testIadr();
    testAddrNack();
    testOverrun();
    testDivider();
    repeat (10) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule